// File: doc/BRIEF.md
# Multiplexed Hex Display Scanner

This block shows two 4-bit values on four seven-segment digits that share one hex-to-segment decoder. Each data bit goes through its own 4-to-1 selector. The low select bit is the scan phase, so the two values take turns at the decoder. The high select bit is a bank button. While the button is released, the value pair reaches digits 0 and 1 unchanged. While it is pressed, the bit-reversed copies of both values reach digits 2 and 3 instead.

The scan phase comes from an internal divider that toggles every `HALF_CLKS` system clocks. When the external-scan input is set, the divider is bypassed and a caller-driven toggle is used instead, which is handy in a testbench. The decoded segments and the digit enables are registered in the same flop stage. They change on the same edge, so a digit never shows the segments meant for another digit.

Top module: `seg_scan_top`

## Requirements
- R1: The segment output is active-high with bit order {g,f,e,d,c,b,a}. Codes 0..F map to 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex).
- R2: With the bank button released, phase low enables digit 0 (dig_en=0001) showing value A, and phase high enables digit 1 (0010) showing value B.
- R3: With the bank button pressed, phase low enables digit 2 (0100) and phase high enables digit 3 (1000). These digits show A and B bit-reversed: bit i of the shown nibble is bit 3-i of the value.
- R4: Exactly one bit of dig_en is set in every cycle.
- R5: seg and dig_en are registered together and reflect the inputs sampled at the previous rising clock edge.
- R6: With external scan off, the scan phase starts low after reset and toggles every HALF_CLKS clocks.
- R7: With external scan on, the phase equals the scan_ext input and the divider has no effect.
- R8: An active-high synchronous reset sets dig_en to 0001, seg to 0, and the divider phase low with its count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_ext_en | input | 1 | 1 selects scan_ext as the phase and bypasses the divider |
| scan_ext | input | 1 | External scan toggle |
| bank_btn | input | 1 | 1 selects the reversed digit pair (digits 2 and 3) |
| val_a | input | 4 | First value |
| val_b | input | 4 | Second value |
| seg | output | 7 | Shared segments, {g,f,e,d,c,b,a}, active high |
| dig_en | output | 4 | One-hot digit enables, active high |

## Verification
A table of value pairs is chosen so that the plain and reversed nibbles differ, with palindromic nibbles such as 6 included. This separates a correct reversal from a missing one or from swapped selector legs. A sweep over all sixteen values of A, with a different B each time, under every button and phase combination, shows that every glyph is decoded and that both pairs are routed. Divider mode is checked by the run lengths of the enables, which expose off-by-one counts. A check just before the clock edge confirms that the outputs are registered.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  localparam int NIB_W = 4;
  localparam int SEG_W = 7;
  localparam int DIG_N = 4;
  localparam int SEL_W = $clog2(DIG_N);

  // Active-high segments, bit order {g,f,e,d,c,b,a}
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [NIB_W-1:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'h0: s = 7'h3F;  4'h1: s = 7'h06;  4'h2: s = 7'h5B;  4'h3: s = 7'h4F;
      4'h4: s = 7'h66;  4'h5: s = 7'h6D;  4'h6: s = 7'h7D;  4'h7: s = 7'h07;
      4'h8: s = 7'h7F;  4'h9: s = 7'h6F;  4'hA: s = 7'h77;  4'hB: s = 7'h7C;
      4'hC: s = 7'h39;  4'hD: s = 7'h5E;  4'hE: s = 7'h79;  default: s = 7'h71;
    endcase
    return s;
  endfunction

  function automatic logic [DIG_N-1:0] digit_onehot(input logic [SEL_W-1:0] s);
    return DIG_N'(1) << s;
  endfunction
endpackage

// File: rtl/scan_divider.sv
module scan_divider #(
  parameter int HALF_CLKS = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic phase,
  output logic tick
);
  localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == CNT_W'(HALF_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/nibble_route.sv
module nibble_route
  import seg_scan_pkg::*;
(
  input  logic [NIB_W-1:0] val_a,
  input  logic [NIB_W-1:0] val_b,
  input  logic [SEL_W-1:0] sel,
  output logic [NIB_W-1:0] nib
);
  // One 4-to-1 selector per bit: legs 0/1 straight, legs 2/3 mirrored
  for (genvar i = 0; i < NIB_W; i++) begin : g_bit
    logic [DIG_N-1:0] legs;
    assign legs   = {val_b[NIB_W-1-i], val_a[NIB_W-1-i], val_b[i], val_a[i]};
    assign nib[i] = legs[sel];
  end
endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
  import seg_scan_pkg::*;
#(
  parameter int HALF_CLKS = 50000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_ext_en,
  input  logic             scan_ext,
  input  logic             bank_btn,
  input  logic [NIB_W-1:0] val_a,
  input  logic [NIB_W-1:0] val_b,
  output logic [SEG_W-1:0] seg,
  output logic [DIG_N-1:0] dig_en
);
  logic             div_phase;
  logic             div_tick;
  logic             scan_phase;
  logic [SEL_W-1:0] route_sel;
  logic [NIB_W-1:0] route_nib;

  scan_divider #(.HALF_CLKS(HALF_CLKS)) u_div (
    .clk   (clk),
    .rst   (rst),
    .phase (div_phase),
    .tick  (div_tick)
  );

  assign scan_phase = scan_ext_en ? scan_ext : div_phase;
  assign route_sel  = {bank_btn, scan_phase};

  nibble_route u_route (
    .val_a (val_a),
    .val_b (val_b),
    .sel   (route_sel),
    .nib   (route_nib)
  );

  // Segments and enables share one register stage to avoid ghosting
  always_ff @(posedge clk) begin
    if (rst) begin
      seg    <= '0;
      dig_en <= digit_onehot('0);
    end else begin
      seg    <= hex_glyph(route_nib);
      dig_en <= digit_onehot(route_sel);
    end
  end
endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk
  import seg_scan_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bank_btn,
  input logic             scan_phase,
  input logic             div_phase,
  input logic             div_tick,
  input logic [SEG_W-1:0] seg,
  input logic [DIG_N-1:0] dig_en
);
  a_r4_one_digit: assert property (@(posedge clk) disable iff (rst)
    $countones(dig_en) == 1);

  a_r2_bank0_pair: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bank_btn)) |-> (dig_en[3:2] == 2'b00));

  a_r3_bank1_pair: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bank_btn)) |-> (dig_en[1:0] == 2'b00));

  a_r5_phase_to_digit: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((dig_en[1] | dig_en[3]) == $past(scan_phase)));

  a_r6_div_toggle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(div_tick)) |-> (div_phase != $past(div_phase)));

  a_r6_div_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(div_tick)) |-> $stable(div_phase));

  a_r8_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (dig_en == 4'b0001 && seg == 7'h00 && !div_phase));
endmodule

bind seg_scan_top seg_scan_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bank_btn   (bank_btn),
  .scan_phase (scan_phase),
  .div_phase  (div_phase),
  .div_tick   (div_tick),
  .seg        (seg),
  .dig_en     (dig_en)
);

// File: tb/seg_scan_top_tb.sv
`timescale 1ns/1ps
module seg_scan_top_tb;
  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scan_ext_en = 1'b1;
  logic       scan_ext = 1'b0;
  logic       bank_btn = 1'b0;
  logic [3:0] val_a = 4'h0;
  logic [3:0] val_b = 4'h0;
  logic [6:0] seg;
  logic [3:0] dig_en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seg_scan_top #(.HALF_CLKS(HALF)) u_dut (
    .clk(clk), .rst(rst), .scan_ext_en(scan_ext_en), .scan_ext(scan_ext),
    .bank_btn(bank_btn), .val_a(val_a), .val_b(val_b),
    .seg(seg), .dig_en(dig_en)
  );

  localparam logic [6:0] GLY [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D,
    7'h7D, 7'h07, 7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

  // {a, b, btn, scan, expected enable, expected shown nibble}
  localparam logic [17:0] VEC [12] = '{
    {4'h3, 4'hC, 1'b0, 1'b0, 4'b0001, 4'h3},
    {4'h3, 4'hC, 1'b0, 1'b1, 4'b0010, 4'hC},
    {4'h3, 4'hC, 1'b1, 1'b0, 4'b0100, 4'hC},
    {4'h3, 4'hC, 1'b1, 1'b1, 4'b1000, 4'h3},
    {4'h1, 4'h8, 1'b1, 1'b0, 4'b0100, 4'h8},
    {4'h1, 4'h8, 1'b1, 1'b1, 4'b1000, 4'h1},
    {4'h6, 4'h2, 1'b1, 1'b0, 4'b0100, 4'h6},
    {4'h6, 4'h2, 1'b1, 1'b1, 4'b1000, 4'h4},
    {4'hA, 4'h5, 1'b0, 1'b0, 4'b0001, 4'hA},
    {4'hA, 4'h5, 1'b1, 1'b0, 4'b0100, 4'h5},
    {4'hE, 4'h7, 1'b1, 1'b1, 4'b1000, 4'hE},
    {4'hF, 4'h0, 1'b0, 1'b1, 4'b0010, 4'h0}
  };

  function automatic logic [3:0] mirror(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  task automatic expect_out(input string req, input logic [6:0] s_exp,
                            input logic [3:0] e_exp);
    checks++;
    if (seg !== s_exp || dig_en !== e_exp) begin
      errors++;
      $display("FAIL %s: seg=%h dig_en=%b expected seg=%h dig_en=%b",
               req, seg, dig_en, s_exp, e_exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b,
                       input logic btn, input logic sc);
    val_a = a; val_b = b; bank_btn = btn; scan_ext = sc;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    expect_out("R8 reset", 7'h00, 4'b0001);
    rst = 1'b0;

    // R2 R3 R1: vector table in external scan mode (R7)
    foreach (VEC[k]) begin
      apply(VEC[k][17:14], VEC[k][13:10], VEC[k][9], VEC[k][8]);
      expect_out(VEC[k][9] ? "R3 table" : "R2 table", GLY[VEC[k][3:0]], VEC[k][7:4]);
    end

    // R1 R2 R3 R4: sweep every A with varied B, both buttons and phases
    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < 4; m++) begin
        logic [3:0] av, bv, shown;
        av = 4'(a);
        bv = 4'(a * 7 + 3);
        apply(av, bv, m[1], m[0]);
        shown = m[1] ? mirror(m[0] ? bv : av) : (m[0] ? bv : av);
        expect_out("R1 sweep", GLY[shown], 4'b0001 << m);
      end
    end

    // R5: output holds until the next edge, then updates
    apply(4'h2, 4'h9, 1'b0, 1'b0);
    val_a = 4'h7;
    #1 expect_out("R5 before edge", GLY[2], 4'b0001);
    @(negedge clk);
    expect_out("R5 after edge", GLY[7], 4'b0001);

    // R7: external toggle drives the phase directly
    apply(4'h4, 4'hB, 1'b0, 1'b1);
    expect_out("R7 ext high", GLY[11], 4'b0010);
    apply(4'h4, 4'hB, 1'b0, 1'b0);
    expect_out("R7 ext low", GLY[4], 4'b0001);

    // R6 R8: divider mode, phase starts low and toggles every HALF clocks
    scan_ext_en = 1'b0;
    scan_ext = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= 4 * HALF; k++) begin
      logic hi;
      @(negedge clk);
      hi = (((k - 1) / HALF) % 2) == 1;
      expect_out("R6 divider", hi ? GLY[11] : GLY[4], hi ? 4'b0010 : 4'b0001);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule